// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Coalescing

This block holds the control word and the status word of one DMA channel, and merges many packet completions into a few interrupts. Software programs the control word through a 32-bit register port. The control word holds the run request, the soft reset request, the interrupt enables, a completion threshold and a completion delay. The data mover next to the block reports each finished packet with a one-cycle pulse. It also raises the idle and halted conditions through two set inputs.

The block has two ways to merge completions. A completion counter starts at the threshold and counts down once per completion. When it reaches zero it raises the completion flag. A delay timer is reloaded by every completion when the delay is nonzero. It counts down on an external prescaler tick, and when it expires it raises the delay flag. Both live values can be read back in the status word. The interrupt output is asserted when any enabled flag is pending. Software clears a flag by writing a one to its bit.

Top module: `dmac_chan_irq`

## Requirements
- R1: The control word (reg_sel=0) is laid out as follows. Bit 0 is run, bit 1 is the tail-pointer mode bit and always reads 1, and bit 2 is soft reset. Bits 14:12 are the interrupt enables, bits 23:16 are the completion threshold and bits 31:24 are the completion delay. All other written bits read back as written.
- R2: After the reset input, the control word reads 0x00010002, the status word reads 0x00010001, and irq is low.
- R3: A completion pulse with a nonzero delay field loads the delay timer with that delay, even if the timer is already running. The timer decrements by one on each tick while it is nonzero. A tick has no effect while the timer is zero, and no other event raises the timer.
- R4: A completion pulse decrements the completion counter. If the counter was 1, status bit 12 is set and the counter reloads from the threshold. A counter at 0 wraps to 255 and sets no flag.
- R5: When the delay timer steps from 1 to 0, status bit 13 is set and the completion counter reloads from the threshold.
- R6: irq is high exactly when some status bit in 14:12 is set and its control enable bit in 14:12 is also set. Writing the status word (reg_sel=1) clears each of bits 14:12 that is written as 1. It leaves the bits written as 0 unchanged, and leaves every other status bit unchanged.
- R7: The status word is laid out as follows. Bit 0 is halted, bit 1 is idle, bits 14:12 are the pending flags, bits 23:16 are the live completion counter and bits 31:24 are the live delay timer. All other bits read 0.
- R8: A control write with run=1, when no reset is in progress, clears halted and idle. A pulse on set_halted or set_idle sets its bit, and it wins over a clear in the same cycle. Every control write reloads the completion counter from the written threshold.
- R9: A control write with bit 2 set restores the reset values, with bit 2 held at 1. While bit 2 is held, later control writes keep it set, and run=1 does not clear halted. The first control read returns bit 2 as 1 and clears it, so the next read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the status word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; combinational while rd_en is high, else 0 |
| cmpl_pulse | input | 1 | One-cycle pulse for each completed packet |
| tmr_tick | input | 1 | One-cycle prescaler tick for the delay timer |
| set_idle | input | 1 | Sets the idle status bit |
| set_halted | input | 1 | Sets the halted status bit |
| irq | output | 1 | Coalesced interrupt request |

## Verification
Each write, completion, tick or set pulse is applied at one clock edge. Its effect is visible on rdata and irq from that edge on, because both are combinational decodes of the registers. Every stimulus is therefore driven after a falling edge and takes effect at the next rising edge. The bench then reads at the following falling edge, one time unit after it drives the read strobe. The one delayed effect is the clearing of the reset bit by a read. That read still returns the bit as 1, and the clear shows only on the next read, which the bench checks as a separate step.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int DATA_W   = 32;
   localparam int RUN_BIT  = 0;
   localparam int TAIL_BIT = 1;
   localparam int SRST_BIT = 2;
   localparam int FLAG_LO  = 12;
   localparam int FLAG_W   = 3;
   localparam int THR_LO   = 16;
   localparam int DLY_LO   = 24;
   localparam int FIELD_W  = 8;
   localparam logic [DATA_W-1:0] CTRL_INIT = 32'h0001_0002;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/dmac_ctrl_reg.sv
module dmac_ctrl_reg
   import dmac_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              rst_held
);
   localparam logic [DATA_W-1:0] TAIL_MASK = DATA_W'(1) << TAIL_BIT;
   localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_INIT;
      end else if (wr) begin
         if (wdata[SRST_BIT])
            ctrl_q <= CTRL_INIT | SRST_MASK;
         else
            ctrl_q <= wdata | TAIL_MASK | (ctrl_q & SRST_MASK);
      end else if (rd) begin
         ctrl_q[SRST_BIT] <= 1'b0;
      end
   end

   assign rst_held = ctrl_q[SRST_BIT];
endmodule

// File: rtl/dmac_coalesce.sv
module dmac_coalesce #(
   parameter int CNT_W    = 8,
   parameter int TMR_W    = 8,
   parameter bit USE_TICK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             tick,
   input  logic             clr,
   input  logic             load_cnt,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] thresh,
   input  logic [TMR_W-1:0] delay,
   output logic [CNT_W-1:0] cnt_q,
   output logic [TMR_W-1:0] tmr_q,
   output logic             ioc_evt,
   output logic             dly_evt
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

   logic step;
   logic restart;

   generate
      if (USE_TICK) begin : g_tick
         assign step = tick;
      end else begin : g_free
         assign step = 1'b1;
      end
   endgenerate

   assign restart = done && (delay != '0) && !clr;
   assign dly_evt = step && (tmr_q == TMR_ONE) && !restart && !clr;
   assign ioc_evt = done && (cnt_q == CNT_ONE) && !load_cnt && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         tmr_q <= '0;
      else if (restart)
         tmr_q <= delay;
      else if (step && tmr_q != '0)
         tmr_q <= tmr_q - TMR_ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= CNT_ONE;
      else if (load_cnt)
         cnt_q <= load_val;
      else if (dly_evt || ioc_evt)
         cnt_q <= thresh;
      else if (done)
         cnt_q <= cnt_q - CNT_ONE;
   end
endmodule

// File: rtl/dmac_chan_irq.sv
module dmac_chan_irq
   import dmac_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int TMR_W    = 8,
   parameter bit USE_TICK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              cmpl_pulse,
   input  logic              tmr_tick,
   input  logic              set_idle,
   input  logic              set_halted,
   output logic              irq
);
   generate
      if (CNT_W < 1 || CNT_W > FIELD_W) begin : g_bad_cnt
         $error("CNT_W must be in 1..8");
      end
      if (TMR_W < 1 || TMR_W > FIELD_W) begin : g_bad_tmr
         $error("TMR_W must be in 1..8");
      end
   endgenerate

   logic              wr_ctrl, wr_stat, rd_ctrl, wr_reset, run_go;
   logic [DATA_W-1:0] ctrl_q, stat_w;
   logic              rst_held;
   logic              halted_q, idle_q;
   logic [FLAG_W-1:0] pend_q, pend_set, pend_clr;
   logic [CNT_W-1:0]  cnt_q, load_val;
   logic [TMR_W-1:0]  tmr_q;
   logic              ioc_evt, dly_evt;

   assign wr_ctrl  = wr_en && (reg_sel == SEL_CTRL);
   assign wr_stat  = wr_en && (reg_sel == SEL_STAT);
   assign rd_ctrl  = rd_en && (reg_sel == SEL_CTRL);
   assign wr_reset = wr_ctrl && wdata[SRST_BIT];
   assign run_go   = wr_ctrl && wdata[RUN_BIT] && !wdata[SRST_BIT] && !rst_held;
   assign load_val = wr_reset ? CNT_W'(CTRL_INIT[THR_LO +: CNT_W])
                              : wdata[THR_LO +: CNT_W];

   dmac_ctrl_reg u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_ctrl),
      .rd       (rd_ctrl),
      .wdata    (wdata),
      .ctrl_q   (ctrl_q),
      .rst_held (rst_held)
   );

   dmac_coalesce #(
      .CNT_W    (CNT_W),
      .TMR_W    (TMR_W),
      .USE_TICK (USE_TICK)
   ) u_coal (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (cmpl_pulse),
      .tick     (tmr_tick),
      .clr      (wr_reset),
      .load_cnt (wr_ctrl),
      .load_val (load_val),
      .thresh   (ctrl_q[THR_LO +: CNT_W]),
      .delay    (ctrl_q[DLY_LO +: TMR_W]),
      .cnt_q    (cnt_q),
      .tmr_q    (tmr_q),
      .ioc_evt  (ioc_evt),
      .dly_evt  (dly_evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || wr_reset) begin
         halted_q <= 1'b1;
         idle_q   <= 1'b0;
      end else begin
         halted_q <= set_halted || (halted_q && !run_go);
         idle_q   <= set_idle   || (idle_q   && !run_go);
      end
   end

   assign pend_set = {1'b0, dly_evt, ioc_evt};
   assign pend_clr = wr_stat ? wdata[FLAG_LO +: FLAG_W] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n || wr_reset)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~pend_clr) | pend_set;
   end

   always_comb begin
      stat_w = '0;
      stat_w[0] = halted_q;
      stat_w[1] = idle_q;
      stat_w[FLAG_LO +: FLAG_W] = pend_q;
      stat_w[THR_LO +: CNT_W]   = cnt_q;
      stat_w[DLY_LO +: TMR_W]   = tmr_q;
   end

   assign rdata = !rd_en ? '0 : (reg_sel == SEL_STAT) ? stat_w : ctrl_q;
   assign irq   = |(pend_q & ctrl_q[FLAG_LO +: FLAG_W]);
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
   parameter int CNT_W = 8,
   parameter int TMR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             reg_sel,
   input logic [31:0]      wdata,
   input logic             cmpl_pulse,
   input logic             tmr_tick,
   input logic             set_idle,
   input logic             set_halted,
   input logic             irq,
   input logic             halted,
   input logic             idle,
   input logic             rst_held,
   input logic [2:0]       pend,
   input logic [CNT_W-1:0] cnt,
   input logic [TMR_W-1:0] tmr,
   input logic [CNT_W-1:0] thresh
);
   // R9
   reset_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !reg_sel && wdata[2] |=> halted && cnt == CNT_W'(1) && tmr == '0 && pend == '0);

   // R8
   run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !reg_sel && wdata[0] && !wdata[2] && !rst_held && !set_halted && !set_idle
      |=> !halted && !idle);

   // R4
   ioc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_pulse && cnt == CNT_W'(1) && !wr_en |=> pend[0]);

   // R5
   dly_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_tick && tmr == TMR_W'(1) && !cmpl_pulse && !wr_en |=> pend[1] && cnt == $past(thresh));

   // R6
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en));

   // R3
   tmr_noraise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmpl_pulse && !wr_en |=> tmr <= $past(tmr));
endmodule

bind dmac_chan_irq dmac_chan_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .reg_sel    (reg_sel),
   .wdata      (wdata),
   .cmpl_pulse (cmpl_pulse),
   .tmr_tick   (tmr_tick),
   .set_idle   (set_idle),
   .set_halted (set_halted),
   .irq        (irq),
   .halted     (halted_q),
   .idle       (idle_q),
   .rst_held   (rst_held),
   .pend       (pend_q),
   .cnt        (cnt_q),
   .tmr        (tmr_q),
   .thresh     (ctrl_q[16 +: CNT_W])
);

// File: tb/tb_dmac_chan_irq.sv
module tb_dmac_chan_irq;
   localparam int CLK_P = 10;
   localparam int NV    = 47;
   localparam logic [1:0] OP_N = 2'd0, OP_W = 2'd1, OP_R = 2'd2;
   // pulse field: {done, tick, set_idle, set_halted}
   typedef struct packed {
      logic [1:0]  op;
      logic        sel;
      logic [31:0] data;
      logic [3:0]  pulses;
      logic [31:0] exp;
      logic        exp_irq;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{OP_R, 1'b0, 32'h0, 4'h0, 32'h0001_0002, 1'b0, 4'd2},  // R2 control reset value
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0001_0001, 1'b0, 4'd2},  // R2 status reset value
      '{OP_W, 1'b0, 32'h0003_1001, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b0, 32'h0, 4'h0, 32'h0003_1003, 1'b0, 4'd1},  // R1 tail bit forced
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0003_0000, 1'b0, 4'd8},  // R8 run clears halted
      '{OP_N, 1'b0, 32'h0, 4'h8, 32'h0, 1'b0, 4'd0},
      '{OP_N, 1'b0, 32'h0, 4'h8, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0001_0000, 1'b0, 4'd4},  // R4 counting down
      '{OP_N, 1'b0, 32'h0, 4'h8, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0003_1000, 1'b1, 4'd4},  // R4 flag and reload
      '{OP_W, 1'b1, 32'h0000_1000, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0003_0000, 1'b0, 4'd6},  // R6 W1C
      '{OP_W, 1'b0, 32'h0502_2001, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_N, 1'b0, 32'h0, 4'h8, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0501_0000, 1'b0, 4'd7},  // R7 live fields
      '{OP_N, 1'b0, 32'h0, 4'h4, 32'h0, 1'b0, 4'd0},
      '{OP_N, 1'b0, 32'h0, 4'h4, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0301_0000, 1'b0, 4'd3},  // R3 tick decrement
      '{OP_N, 1'b0, 32'h0, 4'h4, 32'h0, 1'b0, 4'd0},
      '{OP_N, 1'b0, 32'h0, 4'h4, 32'h0, 1'b0, 4'd0},
      '{OP_N, 1'b0, 32'h0, 4'h4, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0002_2000, 1'b1, 4'd5},  // R5 expiry flag, reload
      '{OP_N, 1'b0, 32'h0, 4'h4, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0002_2000, 1'b1, 4'd3},  // R3 tick at zero ignored
      '{OP_W, 1'b1, 32'h0000_3000, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0002_0000, 1'b0, 4'd6},  // R6 clear both flags
      '{OP_N, 1'b0, 32'h0, 4'h8, 32'h0, 1'b0, 4'd0},
      '{OP_N, 1'b0, 32'h0, 4'h4, 32'h0, 1'b0, 4'd0},
      '{OP_N, 1'b0, 32'h0, 4'h8, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0502_1000, 1'b0, 4'd3},  // R3 restart; R6 masked
      '{OP_W, 1'b1, 32'h0000_1000, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_W, 1'b0, 32'h0000_0004, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_W, 1'b0, 32'h0000_0001, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0000_0001, 1'b0, 4'd9},  // R9 run ignored in reset
      '{OP_R, 1'b0, 32'h0, 4'h0, 32'h0000_0007, 1'b0, 4'd9},  // R9 bit held
      '{OP_R, 1'b0, 32'h0, 4'h0, 32'h0000_0003, 1'b0, 4'd9},  // R9 cleared by read
      '{OP_W, 1'b0, 32'h0004_0001, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0004_0000, 1'b0, 4'd8},  // R8 run, reload
      '{OP_N, 1'b0, 32'h0, 4'h2, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0004_0002, 1'b0, 4'd8},  // R8 set idle
      '{OP_N, 1'b0, 32'h0, 4'h1, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0004_0003, 1'b0, 4'd8},  // R8 set halted
      '{OP_W, 1'b0, 32'h0004_0001, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h0004_0000, 1'b0, 4'd8},  // R8 run clears both
      '{OP_W, 1'b0, 32'h0000_0001, 4'h0, 32'h0, 1'b0, 4'd0},
      '{OP_N, 1'b0, 32'h0, 4'h8, 32'h0, 1'b0, 4'd0},
      '{OP_R, 1'b1, 32'h0, 4'h0, 32'h00FF_0000, 1'b0, 4'd4}   // R4 wrap from zero
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd_en, reg_sel;
   logic [31:0] wdata, rdata;
   logic        cmpl_pulse, tmr_tick, set_idle, set_halted, irq;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dmac_chan_irq dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .reg_sel    (reg_sel),
      .wdata      (wdata),
      .rdata      (rdata),
      .cmpl_pulse (cmpl_pulse),
      .tmr_tick   (tmr_tick),
      .set_idle   (set_idle),
      .set_halted (set_halted),
      .irq        (irq)
   );

   task automatic drive(input logic [1:0] op, input logic sel, input logic [31:0] d,
                        input logic [3:0] p);
      @(negedge clk);
      wr_en      = (op == OP_W);
      rd_en      = (op == OP_R);
      reg_sel    = sel;
      wdata      = d;
      cmpl_pulse = p[3];
      tmr_tick   = p[2];
      set_idle   = p[1];
      set_halted = p[0];
      #1;
   endtask

   task automatic check(input int req, input logic [31:0] exp, input logic exp_irq);
      n_chk++;
      if (rdata !== exp || irq !== exp_irq) begin
         n_fail++;
         $display("FAIL R%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                  req, rdata, irq, exp, exp_irq);
      end
   endtask

   initial begin
      vec_t v;
      rst_n = 1'b0;
      drive(OP_N, 1'b0, 32'h0, 4'h0);
      drive(OP_N, 1'b0, 32'h0, 4'h0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         v = VECS[i];
         drive(v.op, v.sel, v.data, v.pulses);
         if (v.op == OP_R) check(int'(v.req), v.exp, v.exp_irq);
      end
      // R6: write-one-to-clear leaves a flag written as zero
      drive(OP_W, 1'b0, 32'h0001_1001, 4'h0);
      drive(OP_N, 1'b0, 32'h0, 4'h8);
      drive(OP_W, 1'b1, 32'h0000_2000, 4'h0);
      drive(OP_R, 1'b1, 32'h0, 4'h0);
      check(6, 32'h0001_1000, 1'b1);
      // R2: reset input in the middle of activity
      drive(OP_W, 1'b0, 32'h0905_1001, 4'h0);
      drive(OP_N, 1'b0, 32'h0, 4'h8);
      rst_n = 1'b0;
      drive(OP_N, 1'b0, 32'h0, 4'h0);
      drive(OP_N, 1'b0, 32'h0, 4'h0);
      rst_n = 1'b1;
      drive(OP_R, 1'b0, 32'h0, 4'h0);
      check(2, 32'h0001_0002, 1'b0);
      drive(OP_R, 1'b1, 32'h0, 4'h0);
      check(2, 32'h0001_0001, 1'b0);
      drive(OP_N, 1'b0, 32'h0, 4'h0);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule